// File: doc/BRIEF.md
# Read Capture Delay Calibration Engine

This engine trains the read-data capture delay of a DDR memory controller. On a start pulse it steps a delay code upward from zero. For each code it drives a control word that carries the code and writes a fixed 64-word stress pattern through a single-outstanding request/response memory port. It then reads every word back several times in a row and compares each response with the pattern. The sweep looks for the band of codes in which every read is clean, and the engine reports the middle of that band.

Codes that fail before any passing code are skipped. The first clean code opens the window. The first failing code after that closes it and ends the sweep. When calibration is finished, the control word carries the chosen code. If no code passes, an error flag is raised and the chosen code is zero. The pattern comes from an internal ROM that is computed at elaboration, and it is written to consecutive word addresses starting at a base address set by a parameter.

Top module: `rdcal_engine`

## Requirements
- R1: In reset and after it, busy, done, err, req_valid and cal_code are 0, and ctrl_word equals 0x80800800.
- R2: While busy, ctrl_word equals 0x80800800 OR the candidate code in bits [8:0]. Codes start at 0 and only ever advance by one. When idle, ctrl_word equals 0x80800800 OR cal_code.
- R3: For every candidate, the 64 pattern words are written to BASE+0 through BASE+63 in increasing order before any read. Word i is taken from the pair (0x00000000,0xFFFFFFFF), (0xAAAAAAAA,0x55555555), (0xA5A5A5A5,0x5A5A5A5A) or (0xAA55AA55,0x55AA55AA), chosen by i/16. The second word of the pair is used when bit 1 of i XOR bit 3 of i is 1, and the first word otherwise.
- R4: Reads follow address order. On a passing candidate, each word is read READS times (default 10) in a row, for 640 reads in total.
- R5: A response that differs from the pattern fails the candidate at once, and no further read is issued at that code.
- R6: Failing codes before the first passing code are ignored. The first passing code becomes win_first.
- R7: The first failing code after a pass sets win_last to that code minus 1 and ends the sweep. No higher code is driven.
- R8: If no failure follows a pass, win_last is 0x1FF and the sweep ends after code 0x1FF.
- R9: When err is 0, cal_code equals (win_first + win_last) / 2, truncated.
- R10: If no code passes, err is 1 and cal_code is 0.
- R11: busy is high from the cycle after start until done. done is a single-cycle pulse, and busy is low while done is high.
- R12: While req_valid is high and req_ready is low, the request (valid, write, address, data) is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a calibration sweep (sampled while idle) |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse when results are valid |
| err | output | 1 | No passing code was found |
| cal_code | output | 9 | Chosen capture delay code |
| win_first | output | 9 | First passing code |
| win_last | output | 9 | Last passing code of the window |
| ctrl_word | output | 32 | Delay control word to the capture logic |
| req_valid | output | 1 | Memory request valid |
| req_ready | input | 1 | Memory accepts the request |
| req_write | output | 1 | 1 = write, 0 = read |
| req_addr | output | 16 | Word address |
| req_wdata | output | 32 | Write data |
| rsp_valid | input | 1 | Read response valid |
| rsp_rdata | input | 32 | Read response data |

## Verification
Two events can fall on the same candidate. A code can be the first to pass and also be the final code 0x1FF, so the window opens on the same step at which the sweep ends by exhaustion. In the same way, a failure at 0x1FF after earlier passes is both the closing failure and the last code. The bench provokes the first case with a memory model whose clean band is only code 511, and judges it by win_first = win_last = cal_code = 511 and by the highest code seen being 511. A further case puts a flaky read on the tenth repetition of one word inside the band. That case checks that the repeated reads close the window one code early, at the same point where the read count for that code stops at 210.

// File: rtl/rdcal_pkg.sv
package rdcal_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned CTRL_W = 32;

  typedef enum logic [1:0] {
    SQ_IDLE,
    SQ_WRITE,
    SQ_RD_ISSUE,
    SQ_RD_WAIT
  } seq_state_e;

  typedef enum logic [1:0] {
    SW_IDLE,
    SW_LAUNCH,
    SW_WAIT,
    SW_END
  } sweep_state_e;

  // Stress pattern: idx[5:4] picks a complementary pair, and
  // idx[1]^idx[3] picks which member, giving doubled words whose
  // phase flips every four and every eight entries.
  function automatic logic [WORD_W-1:0] pattern_word(input logic [5:0] idx);
    logic [WORD_W-1:0] lo_w;
    logic [WORD_W-1:0] hi_w;
    case (idx[5:4])
      2'd0:    begin lo_w = 32'h0000_0000; hi_w = 32'hFFFF_FFFF; end
      2'd1:    begin lo_w = 32'hAAAA_AAAA; hi_w = 32'h5555_5555; end
      2'd2:    begin lo_w = 32'hA5A5_A5A5; hi_w = 32'h5A5A_5A5A; end
      default: begin lo_w = 32'hAA55_AA55; hi_w = 32'h55AA_55AA; end
    endcase
    return (idx[1] ^ idx[3]) ? hi_w : lo_w;
  endfunction

endpackage

// File: rtl/rdcal_pattern_rom.sv
module rdcal_pattern_rom #(
  parameter int unsigned WORDS = 64,
  localparam int unsigned IW = $clog2(WORDS)
) (
  input  logic [IW-1:0]                idx,
  output logic [rdcal_pkg::WORD_W-1:0] word
);

  logic [rdcal_pkg::WORD_W-1:0] table_q [WORDS];

  for (genvar g = 0; g < WORDS; g++) begin : g_ent
    assign table_q[g] = rdcal_pkg::pattern_word(6'(g));
  end

  assign word = table_q[idx];

endmodule

// File: rtl/rdcal_seq.sv
module rdcal_seq #(
  parameter int unsigned ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int unsigned WORDS     = 64,
  parameter int unsigned READS     = 10,
  localparam int unsigned IW       = $clog2(WORDS),
  localparam int unsigned RW       = (READS > 1) ? $clog2(READS) : 1
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         go,
  output logic                         cand_done,
  output logic                         cand_pass,
  output logic                         req_valid,
  input  logic                         req_ready,
  output logic                         req_write,
  output logic [ADDR_W-1:0]            req_addr,
  output logic [rdcal_pkg::WORD_W-1:0] req_wdata,
  input  logic                         rsp_valid,
  input  logic [rdcal_pkg::WORD_W-1:0] rsp_rdata
);
  import rdcal_pkg::*;

  localparam logic [IW-1:0] LAST_W = IW'(WORDS - 1);
  localparam logic [RW-1:0] LAST_R = RW'(READS - 1);

  seq_state_e        state_q, state_d;
  logic [IW-1:0]     word_q, word_d;
  logic [RW-1:0]     rep_q, rep_d;
  logic              done_q, done_d;
  logic              pass_q, pass_d;
  logic              res_en;
  logic [WORD_W-1:0] exp_word;

  rdcal_pattern_rom #(.WORDS(WORDS)) u_rom (
    .idx  (word_q),
    .word (exp_word)
  );

  always_comb begin
    state_d = state_q;
    word_d  = word_q;
    rep_d   = rep_q;
    done_d  = 1'b0;
    pass_d  = pass_q;
    res_en  = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (go) begin
          state_d = SQ_WRITE;
          word_d  = '0;
          rep_d   = '0;
        end
      end
      SQ_WRITE: begin
        if (req_ready) begin
          if (word_q == LAST_W) begin
            word_d  = '0;
            state_d = SQ_RD_ISSUE;
          end else begin
            word_d = word_q + 1'b1;
          end
        end
      end
      SQ_RD_ISSUE: begin
        if (req_ready) state_d = SQ_RD_WAIT;
      end
      SQ_RD_WAIT: begin
        if (rsp_valid) begin
          if (rsp_rdata != exp_word) begin
            done_d  = 1'b1;
            pass_d  = 1'b0;
            res_en  = 1'b1;
            state_d = SQ_IDLE;
          end else if (rep_q == LAST_R) begin
            rep_d = '0;
            if (word_q == LAST_W) begin
              done_d  = 1'b1;
              pass_d  = 1'b1;
              res_en  = 1'b1;
              state_d = SQ_IDLE;
            end else begin
              word_d  = word_q + 1'b1;
              state_d = SQ_RD_ISSUE;
            end
          end else begin
            rep_d   = rep_q + 1'b1;
            state_d = SQ_RD_ISSUE;
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      word_q  <= '0;
      rep_q   <= '0;
      done_q  <= 1'b0;
      pass_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      word_q  <= word_d;
      rep_q   <= rep_d;
      done_q  <= done_d;
      if (res_en) pass_q <= pass_d;
    end
  end

  assign cand_done = done_q;
  assign cand_pass = pass_q;
  assign req_valid = (state_q == SQ_WRITE) || (state_q == SQ_RD_ISSUE);
  assign req_write = (state_q == SQ_WRITE);
  assign req_addr  = BASE_ADDR + ADDR_W'(word_q);
  assign req_wdata = exp_word;

endmodule

// File: rtl/rdcal_window.sv
module rdcal_window #(
  parameter int unsigned CODE_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cand_done,
  input  logic              cand_pass,
  output logic              seq_go,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [CODE_W-1:0] cand,
  output logic [CODE_W-1:0] win_first,
  output logic [CODE_W-1:0] win_last,
  output logic [CODE_W-1:0] result
);
  import rdcal_pkg::*;

  localparam logic [CODE_W-1:0] CODE_MAX = {CODE_W{1'b1}};

  sweep_state_e      state_q, state_d;
  logic [CODE_W-1:0] cand_q, cand_d;
  logic [CODE_W-1:0] first_q, first_d;
  logic [CODE_W-1:0] last_q, last_d;
  logic [CODE_W-1:0] result_q, result_d;
  logic              found_q, found_d;
  logic              err_q, done_q;
  logic              res_en;
  logic [CODE_W:0]   span_sum;

  assign span_sum = {1'b0, first_q} + {1'b0, last_q};
  assign result_d = found_q ? span_sum[CODE_W:1] : '0;

  always_comb begin
    state_d = state_q;
    cand_d  = cand_q;
    first_d = first_q;
    last_d  = last_q;
    found_d = found_q;
    seq_go  = 1'b0;
    res_en  = 1'b0;
    case (state_q)
      SW_IDLE: begin
        if (start) begin
          state_d = SW_LAUNCH;
          cand_d  = '0;
          first_d = '0;
          last_d  = CODE_MAX;
          found_d = 1'b0;
        end
      end
      SW_LAUNCH: begin
        seq_go  = 1'b1;
        state_d = SW_WAIT;
      end
      SW_WAIT: begin
        if (cand_done) begin
          if (cand_pass) begin
            if (!found_q) begin
              found_d = 1'b1;
              first_d = cand_q;
            end
            if (cand_q == CODE_MAX) state_d = SW_END;
            else begin
              cand_d  = cand_q + 1'b1;
              state_d = SW_LAUNCH;
            end
          end else if (found_q) begin
            last_d  = cand_q - 1'b1;
            state_d = SW_END;
          end else if (cand_q == CODE_MAX) begin
            state_d = SW_END;
          end else begin
            cand_d  = cand_q + 1'b1;
            state_d = SW_LAUNCH;
          end
        end
      end
      SW_END: begin
        res_en  = 1'b1;
        state_d = SW_IDLE;
      end
      default: state_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= SW_IDLE;
      cand_q   <= '0;
      first_q  <= '0;
      last_q   <= '0;
      found_q  <= 1'b0;
      result_q <= '0;
      err_q    <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cand_q  <= cand_d;
      first_q <= first_d;
      last_q  <= last_d;
      found_q <= found_d;
      done_q  <= res_en;
      if (res_en) begin
        result_q <= result_d;
        err_q    <= ~found_q;
      end
    end
  end

  assign busy      = (state_q != SW_IDLE);
  assign done      = done_q;
  assign err       = err_q;
  assign cand      = cand_q;
  assign win_first = first_q;
  assign win_last  = last_q;
  assign result    = result_q;

endmodule

// File: rtl/rdcal_engine.sv
module rdcal_engine #(
  parameter int unsigned CODE_W     = 9,
  parameter int unsigned ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int unsigned WORDS      = 64,
  parameter int unsigned READS      = 10,
  parameter logic [31:0] CTRL_FIXED = 32'h8080_0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic              busy,
  output logic              done,
  output logic              err,
  output logic [CODE_W-1:0] cal_code,
  output logic [CODE_W-1:0] win_first,
  output logic [CODE_W-1:0] win_last,
  output logic [31:0]       ctrl_word,
  output logic              req_valid,
  input  logic              req_ready,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  input  logic              rsp_valid,
  input  logic [31:0]       rsp_rdata
);

  logic              seq_go;
  logic              cand_done;
  logic              cand_pass;
  logic [CODE_W-1:0] cand;
  logic [CODE_W-1:0] ctrl_code;

  rdcal_window #(.CODE_W(CODE_W)) u_window (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cand_done (cand_done),
    .cand_pass (cand_pass),
    .seq_go    (seq_go),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .cand      (cand),
    .win_first (win_first),
    .win_last  (win_last),
    .result    (cal_code)
  );

  rdcal_seq #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR),
    .WORDS     (WORDS),
    .READS     (READS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (seq_go),
    .cand_done (cand_done),
    .cand_pass (cand_pass),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata)
  );

  assign ctrl_code = busy ? cand : cal_code;
  assign ctrl_word = CTRL_FIXED | 32'(ctrl_code);

endmodule

// File: rtl/rdcal_engine_chk.sv
module rdcal_engine_chk #(
  parameter int unsigned CODE_W     = 9,
  parameter int unsigned ADDR_W     = 16,
  parameter logic [31:0] CTRL_FIXED = 32'h8080_0800
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              done,
  input logic              err,
  input logic [CODE_W-1:0] cal_code,
  input logic [CODE_W-1:0] win_first,
  input logic [CODE_W-1:0] win_last,
  input logic [31:0]       ctrl_word,
  input logic              req_valid,
  input logic              req_ready,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic [31:0]       req_wdata
);

  logic [CODE_W-1:0] code_now;
  logic [CODE_W:0]   mid_sum;
  assign code_now = ctrl_word[CODE_W-1:0];
  assign mid_sum  = {1'b0, win_first} + {1'b0, win_last};

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !req_valid);

  assert_ctrl_fixed_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_word & CTRL_FIXED) == CTRL_FIXED);

  assert_code_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && code_now != $past(code_now)) |->
      code_now == $past(code_now) + 1'b1);

  assert_window_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> win_first <= win_last);

  assert_mid_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !err) |-> cal_code == mid_sum[CODE_W:1]);

  assert_err_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (done && err) |-> cal_code == '0);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=>
      (req_valid && $stable(req_write) && $stable(req_addr) && $stable(req_wdata)));

endmodule

bind rdcal_engine rdcal_engine_chk #(
  .CODE_W     (CODE_W),
  .ADDR_W     (ADDR_W),
  .CTRL_FIXED (CTRL_FIXED)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .busy      (busy),
  .done      (done),
  .err       (err),
  .cal_code  (cal_code),
  .win_first (win_first),
  .win_last  (win_last),
  .ctrl_word (ctrl_word),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_write (req_write),
  .req_addr  (req_addr),
  .req_wdata (req_wdata)
);

// File: tb/test_rdcal_engine.sv
module test_rdcal_engine;

  localparam int          MAXC = 511;
  localparam logic [15:0] BASE = 16'h0400;
  localparam int          NV   = 7;
  // lo, hi, flaky code, exp first, exp last, exp result, exp err
  localparam int VEC [NV][7] = '{
    '{  5,   9,  -1,   5,   9,   7, 0},
    '{  0,   3,  -1,   0,   3,   1, 0},
    '{ 20,  40,  30,  20,  29,  24, 0},
    '{100, 100,  -1, 100, 100, 100, 0},
    '{  2,   7,   7,   2,   6,   4, 0},
    '{511, 511,  -1, 511, 511, 511, 0},
    '{600, 600,  -1,   0,   0,   0, 1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        busy, done, err;
  logic [8:0]  cal_code, win_first, win_last;
  logic [31:0] ctrl_word;
  logic        req_valid, req_write;
  logic        req_ready = 1'b0;
  logic [15:0] req_addr;
  logic [31:0] req_wdata;
  logic        rsp_valid = 1'b0;
  logic [31:0] rsp_rdata = 32'h0;

  always #4 clk = ~clk;

  rdcal_engine #(.BASE_ADDR(BASE)) i_rdcal_engine (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
    .err(err), .cal_code(cal_code), .win_first(win_first), .win_last(win_last),
    .ctrl_word(ctrl_word), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int cfg_lo = 0, cfg_hi = 0, cfg_fl = -1;
  int max_code, wr_exp, wr_bad, rd_bad, prev_rd_idx, flk_cnt;
  int rdcnt [512];
  logic [31:0] mem [64];

  function automatic logic [31:0] ref_pat(int i);
    logic [31:0] a, b;
    int grp = i / 16;
    if (grp == 0)      begin a = 32'h00000000; b = 32'hFFFFFFFF; end
    else if (grp == 1) begin a = 32'hAAAAAAAA; b = 32'h55555555; end
    else if (grp == 2) begin a = 32'hA5A5A5A5; b = 32'h5A5A5A5A; end
    else               begin a = 32'hAA55AA55; b = 32'h55AA55AA; end
    return ((((i >> 1) ^ (i >> 3)) & 1) == 1) ? b : a;
  endfunction

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: ready stalls one cycle in eight; reads outside the band return inverted data
  always @(posedge clk) begin
    cyc <= cyc + 1;
    req_ready <= ((cyc % 8) != 6);
    rsp_valid <= 1'b0;
    if (rst_n && req_valid && req_ready) begin
      int idx;
      int code;
      bit corrupt;
      idx  = int'(req_addr) - int'(BASE);
      code = int'(ctrl_word[8:0]);
      if (code > max_code) max_code = code;
      if (req_write) begin
        if (idx == 0) wr_exp = 0;
        if (idx != wr_exp || req_wdata != ref_pat(idx & 63)) wr_bad++;
        wr_exp++;
        mem[idx & 63] = req_wdata;
        if (idx == 20) flk_cnt = 0;
        prev_rd_idx = -1;
      end else begin
        rdcnt[code]++;
        if (idx < 0 || idx > 63 || wr_exp != 64 ||
            (idx != prev_rd_idx && idx != prev_rd_idx + 1)) rd_bad++;
        prev_rd_idx = idx;
        corrupt = (code < cfg_lo) || (code > cfg_hi);
        if (code == cfg_fl && idx == 20) begin
          flk_cnt++;
          if (flk_cnt == 10) corrupt = 1'b1;
        end
        rsp_valid <= 1'b1;
        rsp_rdata <= corrupt ? ~mem[idx & 63] : mem[idx & 63];
      end
    end
  end

  task automatic run_case(input int v);
    int lo, hi, fl, ef, el, er, ee, n, exp_max;
    lo = VEC[v][0]; hi = VEC[v][1]; fl = VEC[v][2];
    ef = VEC[v][3]; el = VEC[v][4]; er = VEC[v][5]; ee = VEC[v][6];
    @(negedge clk);
    cfg_lo = lo; cfg_hi = hi; cfg_fl = fl;
    for (int k = 0; k < 512; k++) rdcnt[k] = 0;
    max_code = -1; wr_exp = 0; wr_bad = 0; rd_bad = 0; prev_rd_idx = -1; flk_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R11 busy after start", busy, 1);
    n = 0;
    while (!done && n < 60000) begin
      @(negedge clk);
      n++;
    end
    chk(done == 1'b1, "R11 done reached", done, 1);
    chk(busy == 1'b0, "R11 busy low at done", busy, 0);
    chk(err == ee[0], "R10 err flag", err, ee);
    chk(cal_code == 9'(er), "R9 result", cal_code, er);
    chk(ctrl_word == (32'h80800800 | 32'(er)), "R2 final ctrl word", ctrl_word, 32'h80800800 | 32'(er));
    if (ee == 0) begin
      chk(win_first == 9'(ef), "R6 window start", win_first, ef);
      chk(win_last == 9'(el), "R7 R8 window end", win_last, el);
    end
    @(negedge clk);
    chk(done == 1'b0, "R11 done one cycle", done, 0);
    chk(wr_bad == 0, "R3 write order and pattern", wr_bad, 0);
    chk(rd_bad == 0, "R4 read order", rd_bad, 0);
    exp_max = (ee == 1 || el == MAXC) ? MAXC : el + 1;
    chk(max_code == exp_max, "R7 highest code driven", max_code, exp_max);
    if (ee == 0 && lo < hi && lo != fl)
      chk(rdcnt[lo] == 640, "R4 reads on passing code", rdcnt[lo], 640);
    if (ee == 0 && lo > 0)
      chk(rdcnt[lo - 1] == 1, "R5 R6 failing code before window", rdcnt[lo - 1], 1);
    if (ee == 1)
      chk(rdcnt[0] == 1, "R5 R10 failing code zero", rdcnt[0], 1);
    if (fl >= 0)
      chk(rdcnt[fl] == 210, "R5 flaky code stops on mismatch", rdcnt[fl], 210);
  endtask

  initial begin
    #(8 * 190000);
    chk(1'b0, "watchdog", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    for (int k = 0; k < 64; k++) mem[k] = 32'h0;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && err == 1'b0, "R1 flags in reset", {busy, done, err}, 0);
    chk(req_valid == 1'b0, "R1 no request in reset", req_valid, 0);
    chk(ctrl_word == 32'h80800800, "R1 ctrl word in reset", ctrl_word, 32'h80800800);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cal_code == 9'd0 && busy == 1'b0, "R1 state after reset", cal_code, 0);
    chk(ctrl_word == 32'h80800800, "R1 ctrl word after reset", ctrl_word, 32'h80800800);
    for (int v = 0; v < NV; v++) run_case(v);
    // R2 idle control word follows the last result after a further idle cycle
    @(negedge clk);
    chk(ctrl_word == 32'h80800800, "R2 idle ctrl after error sweep", ctrl_word, 32'h80800800);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule